// File: doc/BRIEF.md
# Priority and Circuit Output-Port Allocator

This block decides which of several switch inputs may drive one output of a wormhole network switch. Every input shows its current flit and a valid bit. The allocator can do three things. It lets each head flit ask for a priority level. It lets any input reserve the output as a guaranteed circuit by sending an in-band open packet, and release it later with a close packet. When neither of these applies, it shares the output fairly by round-robin.

The winner of a packet keeps the output until that packet's tail flit has passed. Each accepted flit is placed in an output register, together with the index of the input it came from. The open and close flits are sent on downstream unchanged, so the switches further along the path can configure themselves the same way. The per-input circuit flags are visible as an output.

Flit layout (FLIT_W = 48):
- Bits [47:46] give the flit kind.
- Bits [45:44] carry the circuit command.
- Bits [43:41] carry the priority level.
- The bits below these are payload.

Top module: `qos_port_alloc`

## Requirements
- R1: While `rst` is high, `out_valid` is 0, `circ_state` is all zero and `in_ready` is all zero. After reset the round-robin pointer starts at input 0.
- R2: Flit kind is coded in bits [47:46]: 00 body, 01 head, 10 tail, 11 single-flit packet. Bit 46 set marks the start of a packet and bit 47 set marks its end. When the output is not held by a packet, only inputs showing a start flit are considered.
- R3: The priority level is in bits [43:41] of a start flit, with 0 as the default. Among the eligible inputs, the highest level wins.
- R4: A tie at the top level goes to the first eligible input found by scanning cyclically from the round-robin pointer. When a packet's end flit is accepted, the pointer moves to the winner's index plus one, modulo N_IN.
- R5: Once a start flit is accepted from an input, only that input is served until its end flit is accepted. Packets never interleave, even when a higher-priority head is waiting.
- R6: The command is in bits [45:44]: 01 open, 10 close, 00 none. When a start flit carrying open is accepted from input i, circuit flag i is set. When a start flit carrying close is accepted, the flag is cleared. Both kinds of flit are forwarded to the output unchanged.
- R7: While any circuit flag is set, a new packet may be granted only to an input whose flag is set, whatever the levels of the other inputs.
- R8: While `out_valid` is high and `out_ready` is low, `out_flit`, `out_src` and `out_valid` keep their values and no `in_ready` bit is raised.
- R9: `in_ready` is one-hot or zero. A bit rises only in a cycle where that input's flit is actually taken, and only while its `in_valid` is high.
- R10: A flit taken in cycle t appears on `out_flit` in cycle t+1, with `out_valid` high and `out_src` equal to the index of its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_flit | input | N_IN*FLIT_W | Current flit of every input, input i in slice i |
| in_valid | input | N_IN | Input i shows a flit |
| in_ready | output | N_IN | Flit of input i is taken this cycle |
| out_flit | output | FLIT_W | Registered output flit |
| out_valid | output | 1 | Output flit is valid |
| out_ready | input | 1 | Downstream accepts the output flit |
| out_src | output | $clog2(N_IN) | Input index of the flit on the output |
| circ_state | output | N_IN | Per-input circuit-established flags |

## Verification
Two kinds of events can land in the same cycle. The first is a new head being picked by priority and round-robin while the previous packet's tail is only just leaving. The second is a downstream stall arriving while a packet is held. The bench provokes both by loading every input with multi-flit packets at mixed levels, leaving random gaps in `in_valid` and driving `out_ready` randomly. A behavioural reference model, updated on every clock, predicts `in_ready`, the output register and the circuit flags. Separate stream checks judge the head order, confirm there is no interleaving, and confirm that nothing but the reserved input is served between an observed open flit and its close.

// File: rtl/qos_arb_pkg.sv
package qos_arb_pkg;
  localparam int KIND_W = 2;
  localparam int CMD_W  = 2;

  typedef enum logic [CMD_W-1:0] {
    CMD_NONE  = 2'b00,
    CMD_OPEN  = 2'b01,
    CMD_CLOSE = 2'b10,
    CMD_RSVD  = 2'b11
  } qos_cmd_e;
endpackage

// File: rtl/qos_detect.sv
module qos_detect
  import qos_arb_pkg::*;
#(
  parameter int FLIT_W = 48,
  parameter int LVL_W  = 3
) (
  input  logic [FLIT_W-1:0] flit,
  input  logic              valid,
  output logic              starts,
  output logic              ends,
  output logic              open_req,
  output logic              close_req,
  output logic [LVL_W-1:0]  level
);
  localparam int KIND_LSB = FLIT_W - KIND_W;
  localparam int CMD_LSB  = KIND_LSB - CMD_W;
  localparam int LVL_LSB  = CMD_LSB - LVL_W;

  qos_cmd_e cmd;

  always_comb begin
    cmd       = qos_cmd_e'(flit[CMD_LSB +: CMD_W]);
    starts    = valid & flit[KIND_LSB];
    ends      = flit[KIND_LSB+1];
    open_req  = starts & (cmd == CMD_OPEN);
    close_req = starts & (cmd == CMD_CLOSE);
    level     = flit[LVL_LSB +: LVL_W];
  end
endmodule

// File: rtl/qos_pick.sv
module qos_pick #(
  parameter int N_IN  = 4,
  parameter int LVL_W = 3,
  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic [N_IN-1:0]       elig,
  input  logic [N_IN*LVL_W-1:0] lvl,
  input  logic [IDX_W-1:0]      ptr,
  output logic                  found,
  output logic [IDX_W-1:0]      win
);
  logic [LVL_W-1:0] top;
  int               j;

  always_comb begin
    top = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (elig[i] && (lvl[i*LVL_W +: LVL_W] > top)) top = lvl[i*LVL_W +: LVL_W];
    end
    found = 1'b0;
    win   = '0;
    j     = 0;
    for (int k = 0; k < N_IN; k++) begin
      j = int'(ptr) + k;
      if (j >= N_IN) j = j - N_IN;
      if (!found && elig[j] && (lvl[j*LVL_W +: LVL_W] == top)) begin
        found = 1'b1;
        win   = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/qos_circuit_reg.sv
module qos_circuit_reg #(
  parameter int N_IN = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] set_vec,
  input  logic [N_IN-1:0] clr_vec,
  output logic [N_IN-1:0] circ
);
  always_ff @(posedge clk) begin
    if (rst) circ <= '0;
    else     circ <= (circ & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/qos_port_alloc.sv
module qos_port_alloc #(
  parameter int N_IN   = 4,
  parameter int FLIT_W = 48,
  parameter int LVL_W  = 3,
  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_IN*FLIT_W-1:0]   in_flit,
  input  logic [N_IN-1:0]          in_valid,
  output logic [N_IN-1:0]          in_ready,
  output logic [FLIT_W-1:0]        out_flit,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [IDX_W-1:0]         out_src,
  output logic [N_IN-1:0]          circ_state
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_IN - 1);

  logic [N_IN-1:0]       starts, ends, open_req, close_req, elig;
  logic [N_IN*LVL_W-1:0] lvl;
  logic                  locked, adv, found, take_any;
  logic [IDX_W-1:0]      owner, ptr, win, take_idx;
  logic [N_IN-1:0]       set_vec, clr_vec;
  logic [FLIT_W-1:0]     sel_flit;

  for (genvar g = 0; g < N_IN; g++) begin : g_det
    qos_detect #(.FLIT_W(FLIT_W), .LVL_W(LVL_W)) u_det (
      .flit      (in_flit[g*FLIT_W +: FLIT_W]),
      .valid     (in_valid[g]),
      .starts    (starts[g]),
      .ends      (ends[g]),
      .open_req  (open_req[g]),
      .close_req (close_req[g]),
      .level     (lvl[g*LVL_W +: LVL_W])
    );
  end

  // Circuit holders shut out every other input.
  assign elig = starts & ((|circ_state) ? circ_state : {N_IN{1'b1}});

  qos_pick #(.N_IN(N_IN), .LVL_W(LVL_W)) u_pick (
    .elig  (elig),
    .lvl   (lvl),
    .ptr   (ptr),
    .found (found),
    .win   (win)
  );

  always_comb begin
    adv      = ~out_valid | out_ready;
    take_any = 1'b0;
    take_idx = locked ? owner : win;
    if (!rst && adv) begin
      if (locked) take_any = in_valid[owner];
      else        take_any = found;
    end
    in_ready = '0;
    if (take_any) in_ready[take_idx] = 1'b1;
    sel_flit = in_flit[take_idx*FLIT_W +: FLIT_W];
    set_vec  = (take_any && !locked) ? (open_req & in_ready) : '0;
    clr_vec  = (take_any && !locked) ? (close_req & in_ready) : '0;
  end

  qos_circuit_reg #(.N_IN(N_IN)) u_circ (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .circ    (circ_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_flit  <= '0;
      out_src   <= '0;
      locked    <= 1'b0;
      owner     <= '0;
      ptr       <= '0;
    end else if (adv) begin
      out_valid <= take_any;
      if (take_any) begin
        out_flit <= sel_flit;
        out_src  <= take_idx;
        if (ends[take_idx]) begin
          locked <= 1'b0;
          ptr    <= (take_idx == LAST) ? '0 : take_idx + 1'b1;
        end else begin
          locked <= 1'b1;
          owner  <= take_idx;
        end
      end
    end
  end
endmodule

// File: rtl/qos_port_alloc_chk.sv
module qos_port_alloc_chk #(
  parameter int N_IN   = 4,
  parameter int FLIT_W = 48,
  parameter int LVL_W  = 3,
  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic [N_IN*FLIT_W-1:0] in_flit,
  input logic [N_IN-1:0]        in_valid,
  input logic [N_IN-1:0]        in_ready,
  input logic [FLIT_W-1:0]      out_flit,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [IDX_W-1:0]       out_src,
  input logic [N_IN-1:0]        circ_state
);
  logic              taken, busy, t_open;
  logic [IDX_W-1:0]  idx, own;
  logic [FLIT_W-1:0] tflit;

  always_comb begin
    taken = |in_ready;
    idx   = '0;
    for (int i = 0; i < N_IN; i++) if (in_ready[i]) idx = IDX_W'(i);
    tflit  = in_flit[idx*FLIT_W +: FLIT_W];
    t_open = tflit[FLIT_W-2] && (tflit[FLIT_W-3 -: 2] == 2'b01);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      own  <= '0;
    end else if (taken) begin
      busy <= ~tflit[FLIT_W-1];
      own  <= idx;
    end
  end

  assert_onehot_take_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(in_ready));
  assert_take_valid_R9: assert property (@(posedge clk) disable iff (rst)
    (in_ready & ~in_valid) == '0);
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_flit) && $stable(out_src)));
  assert_stall_no_take_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> (in_ready == '0));
  assert_reg_out_R10: assert property (@(posedge clk) disable iff (rst)
    taken |=> (out_valid && out_src == $past(idx) && out_flit == $past(tflit)));
  assert_no_interleave_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && taken) |-> (idx == own));
  assert_circuit_excl_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && taken && (|circ_state)) |-> circ_state[idx]);
  assert_open_sets_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy && taken && t_open) |=> circ_state[$past(idx)]);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |-> (in_ready == '0));
endmodule

bind qos_port_alloc qos_port_alloc_chk #(.N_IN(N_IN), .FLIT_W(FLIT_W), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/qos_port_alloc_test.sv
module qos_port_alloc_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int FW = 48;
  localparam int QD = 64;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [N*FW-1:0]   in_flit = '0;
  logic [N-1:0]      in_valid = '0;
  logic [N-1:0]      in_ready;
  logic [FW-1:0]     out_flit;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [1:0]        out_src;
  logic [N-1:0]      circ_state;

  qos_port_alloc #(.N_IN(N), .FLIT_W(FW), .LVL_W(3)) uut (
    .clk(clk), .rst(rst), .in_flit(in_flit), .in_valid(in_valid), .in_ready(in_ready),
    .out_flit(out_flit), .out_valid(out_valid), .out_ready(out_ready),
    .out_src(out_src), .circ_state(circ_state)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [FW-1:0] mem [N][QD];
  int hd [N];
  int tl [N];
  bit gaps = 0, rnd_rdy = 0;

  // reference model state
  bit            m_ov, m_locked;
  logic [FW-1:0] m_of;
  int            m_src, m_owner, m_ptr;
  logic [N-1:0]  m_circ;

  int            obs_src [$];
  logic [FW-1:0] obs_flit [$];

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [FW-1:0] mk(logic [1:0] kind, logic [1:0] cmd, int lvl, int src, int seq);
    logic [40:0] p;
    p = '0;
    p[23:16] = 8'(src);
    p[15:0]  = 16'(seq);
    return {kind, cmd, 3'(lvl), p};
  endfunction

  task automatic push(int i, logic [FW-1:0] f);
    mem[i][tl[i]] = f;
    tl[i]++;
  endtask

  task automatic cyc();
    int take, best, bestlvl, ii;
    bit adv, circany;
    logic [FW-1:0] f;
    logic [N-1:0] exp_rdy;
    @(negedge clk);
    check("R10 out_valid", 64'(out_valid), 64'(m_ov));
    check("R10 out_flit", 64'(out_flit), 64'(m_of));
    check("R10 out_src", 64'(out_src), 64'(m_src));
    check("R6 circ_state", 64'(circ_state), 64'(m_circ));
    for (int i = 0; i < N; i++) begin
      bit have;
      have = hd[i] < tl[i];
      in_valid[i] = have && (!gaps || $urandom_range(3) != 0);
      in_flit[i*FW +: FW] = have ? mem[i][hd[i]] : '0;
    end
    out_ready = rnd_rdy ? ($urandom_range(2) != 0) : 1'b1;
    #1;
    adv = !m_ov || out_ready;
    take = -1;
    if (adv) begin
      if (m_locked) begin
        if (in_valid[m_owner]) take = m_owner;
      end else begin
        circany = |m_circ;
        best = -1; bestlvl = -1;
        for (int k = 0; k < N; k++) begin
          ii = (m_ptr + k) % N;
          f = in_flit[ii*FW +: FW];
          if (in_valid[ii] && f[46] && (!circany || m_circ[ii]) && int'(f[43:41]) > bestlvl) begin
            best = ii; bestlvl = int'(f[43:41]);
          end
        end
        take = best;
      end
    end
    exp_rdy = '0;
    if (take >= 0) exp_rdy[take] = 1'b1;
    check("R9 R3 R4 R5 R7 in_ready", 64'(in_ready), 64'(exp_rdy));
    if (out_valid && out_ready) begin
      obs_src.push_back(int'(out_src));
      obs_flit.push_back(out_flit);
    end
    if (adv) begin
      m_ov = (take >= 0);
      if (take >= 0) begin
        f = in_flit[take*FW +: FW];
        m_of = f; m_src = take;
        if (!m_locked && f[45:44] == 2'b01) m_circ[take] = 1'b1;
        if (!m_locked && f[45:44] == 2'b10) m_circ[take] = 1'b0;
        if (f[47]) begin m_locked = 0; m_ptr = (take + 1) % N; end
        else begin m_locked = 1; m_owner = take; end
        hd[take]++;
      end
    end
  endtask

  function automatic bit all_empty();
    for (int i = 0; i < N; i++) if (hd[i] < tl[i]) return 0;
    return 1;
  endfunction

  task automatic drain();
    int n = 0;
    do begin cyc(); n++; end while ((!all_empty() || m_ov) && n < 5000);
    for (int i = 0; i < N; i++) begin hd[i] = 0; tl[i] = 0; end
  endtask

  // list of source indices of packet heads observed from position 'from'
  task automatic head_order(int from, output int hs [$]);
    hs = {};
    for (int k = from; k < obs_flit.size(); k++) if (obs_flit[k][46]) hs.push_back(obs_src[k]);
  endtask

  task automatic stream_checks(int from, int expected_cnt, string tag);
    int cur; bit bad;
    cur = -1; bad = 0;
    for (int k = from; k < obs_flit.size(); k++) begin
      if (cur >= 0 && obs_src[k] != cur) bad = 1;
      if (int'(obs_flit[k][23:16]) != obs_src[k]) bad = 1;
      if (obs_flit[k][47:46] == 2'b01) cur = obs_src[k];
      if (obs_flit[k][47]) cur = -1;
    end
    check({tag, " R5 no interleave"}, 64'(bad), 64'(0));
    check({tag, " R5 flit count"}, 64'(obs_flit.size() - from), 64'(expected_cnt));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end");
    finish_run();
  end

  initial begin
    int mark, hs [$], cnt, iopen, iclose;
    bit bad;
    for (int i = 0; i < N; i++) begin hd[i] = 0; tl[i] = 0; end
    m_ov = 0; m_of = '0; m_src = 0; m_locked = 0; m_owner = 0; m_ptr = 0; m_circ = '0;

    // R1: reset holds everything idle even with heads presented
    for (int i = 0; i < N; i++) in_flit[i*FW +: FW] = mk(2'b11, 2'b01, 7, i, 0);
    in_valid = '1;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", 64'(out_valid), 64'(0));
    check("R1 in_ready in reset", 64'(in_ready), 64'(0));
    check("R1 circ_state in reset", 64'(circ_state), 64'(0));
    in_valid = '0;
    rst = 1'b0;

    // R3 R4: levels 0,5,2,5 with two-flit packets, pointer starts at 0
    mark = obs_flit.size();
    push(0, mk(2'b01,0,0,0,1)); push(0, mk(2'b10,0,0,0,2));
    push(1, mk(2'b01,0,5,1,1)); push(1, mk(2'b10,0,5,1,2));
    push(2, mk(2'b01,0,2,2,1)); push(2, mk(2'b10,0,2,2,2));
    push(3, mk(2'b01,0,5,3,1)); push(3, mk(2'b10,0,5,3,2));
    drain();
    head_order(mark, hs);
    check("R3 R4 head count", 64'(hs.size()), 64'(4));
    if (hs.size() == 4) begin
      check("R3 R4 first head", 64'(hs[0]), 64'(1));
      check("R3 R4 second head", 64'(hs[1]), 64'(3));
      check("R3 third head", 64'(hs[2]), 64'(2));
      check("R3 fourth head", 64'(hs[3]), 64'(0));
    end
    stream_checks(mark, 8, "prio");

    // R4 R2: equal level single-flit packets, pointer now at 1; body flit alone is ignored
    mark = obs_flit.size();
    for (int i = 0; i < N; i++) begin
      push(i, mk(2'b11,0,3,i,10)); push(i, mk(2'b11,0,3,i,11));
    end
    drain();
    head_order(mark, hs);
    check("R4 rr count", 64'(hs.size()), 64'(8));
    if (hs.size() == 8)
      for (int k = 0; k < 8; k++) check("R4 rr order", 64'(hs[k]), 64'((k + 1) % N));
    mark = obs_flit.size();
    push(2, mk(2'b00,0,7,2,20));
    repeat (6) cyc();
    check("R2 lone body flit not taken", 64'(obs_flit.size() - mark), 64'(0));
    check("R2 lone body out_valid", 64'(out_valid), 64'(0));
    for (int i = 0; i < N; i++) begin hd[i] = 0; tl[i] = 0; end

    // R5 R8 R9: random levels, lengths, gaps and back-pressure
    gaps = 1; rnd_rdy = 1;
    mark = obs_flit.size(); cnt = 0;
    for (int i = 0; i < N; i++)
      for (int p = 0; p < 5; p++) begin
        int len, lv;
        len = 1 + $urandom_range(4); lv = $urandom_range(7);
        for (int b = 0; b < len; b++) begin
          logic [1:0] kd;
          kd = (len == 1) ? 2'b11 : (b == 0) ? 2'b01 : (b == len-1) ? 2'b10 : 2'b00;
          push(i, mk(kd, 0, lv, i, p*8 + b));
          cnt++;
        end
      end
    drain();
    stream_checks(mark, cnt, "random");
    gaps = 0; rnd_rdy = 0;

    // R6 R7: input 2 reserves the output, others wait at top level
    mark = obs_flit.size();
    push(2, mk(2'b11,2'b01,0,2,30));
    for (int k = 0; k < 10 && !circ_state[2]; k++) cyc();
    check("R6 open sets flag", 64'(circ_state), 64'(4'b0100));
    for (int i = 0; i < N; i++) if (i != 2) begin
      push(i, mk(2'b01,0,7,i,40)); push(i, mk(2'b10,0,7,i,41));
    end
    for (int p = 0; p < 2; p++) begin
      push(2, mk(2'b01,0,0,2,50+p)); push(2, mk(2'b00,0,0,2,60+p)); push(2, mk(2'b10,0,0,2,70+p));
    end
    push(2, mk(2'b11,2'b10,0,2,80));
    drain();
    iopen = -1; iclose = -1;
    for (int k = mark; k < obs_flit.size(); k++) begin
      if (obs_flit[k][45:44] == 2'b01 && iopen < 0) iopen = k;
      if (obs_flit[k][45:44] == 2'b10 && iclose < 0) iclose = k;
    end
    check("R6 open flit forwarded", 64'(iopen >= 0), 64'(1));
    check("R6 close flit forwarded", 64'(iclose > iopen), 64'(1));
    bad = 0;
    for (int k = iopen; k >= 0 && k <= iclose; k++) if (obs_src[k] != 2) bad = 1;
    check("R7 exclusive between open and close", 64'(bad), 64'(0));
    check("R6 close clears flag", 64'(circ_state), 64'(0));
    stream_checks(mark, 14, "circuit");

    finish_run();
  end
endmodule